// File: doc/BRIEF.md
# Dual-Channel Converter Bus Interface

This block is the digital front end of a two-channel, 8-bit converter device that sits on a microprocessor-style asynchronous parallel bus. The host selects the device with an active-low chip select. It picks either the converter input side (ADC) or the converter output side (DAC) with one select pin, and channel A or B with another. It then pulses an active-low read or write strobe. A write to the DAC side latches the bus byte into that channel's output code register. A write to the ADC side starts a conversion on the chosen channel. A read from the ADC side places the most recent conversion result on the bus.

An active-low interrupt reports conversion status. It is released (driven high) when the host begins a read or write strobe addressed to the ADC side, and it is pulled low when a conversion finishes. The analog conversion is modelled as a fixed number of clock cycles. At the end of that time the sample presented on the chosen channel's sample input is captured as the result.

All bus pins are brought into the internal clock domain through two-flop synchronisers, and strobe edges are detected after synchronisation. As a result, each bus action takes effect three clock edges after the pin changes. Codes are offset binary, so 0x80 is the mid-scale value.

Top module: `dualconv_bus`

## Requirements
- R1: After synchronous reset, both DAC code registers read 0x80, the conversion result is 0x80, `int_n` is 1 and `data_oe` is 0.
- R2: With `cs_n` low and `sel_dac` = 1, a rising edge of `wr_n` loads `data_in` into DAC A when `sel_chb` = 0, or into DAC B when `sel_chb` = 1. The other channel's register is unchanged.
- R3: While `cs_n` is high, strobes have no effect: DAC registers keep their values, no conversion starts, and `data_oe` stays 0.
- R4: With `cs_n` low and `sel_dac` = 0, a rising edge of `wr_n` starts a conversion on the channel given by `sel_chb` (0 = A, 1 = B). `CONV_CYCLES` clock cycles later, the sample on that channel's input is stored as the result and `int_n` goes low.
- R5: With `cs_n` low and `sel_dac` = 0, a falling edge of `rd_n` or of `wr_n` drives `int_n` high.
- R6: `data_oe` is 1 only while the synchronised `cs_n` and `rd_n` are both low and `sel_dac` = 0. In that state `data_out` carries the last result, with bit 7 as the MSB.
- R7: A conversion start that arrives while a conversion is still running abandons the old one and restarts the full latency on the newly selected channel. No completion occurs for the abandoned conversion.
- R8: Strobes addressed to the DAC side (`sel_dac` = 1) never change `int_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; action on rising edge |
| sel_dac | input | 1 | 1 addresses the DAC side, 0 the ADC side |
| sel_chb | input | 1 | 1 selects channel B, 0 channel A |
| data_in | input | 8 | Bus data into the block |
| data_out | output | 8 | Bus data out of the block (zero when not enabled) |
| data_oe | output | 1 | Bus driver enable for `data_out` |
| samp_a | input | 8 | Digitised sample of channel A |
| samp_b | input | 8 | Digitised sample of channel B |
| dac_a_code | output | 8 | DAC A output code |
| dac_b_code | output | 8 | DAC B output code |
| int_n | output | 1 | Conversion-done interrupt, active low |

## Verification
The hardest case to reach from the pins is the restart of R7. A second ADC write must land inside the busy window of the first one, and the bench must then show that the first conversion never completes. The stimulus starts a conversion on channel A, waits about eight cycles, and starts one on channel B. It then samples `int_n` after the point where A would have finished, where `int_n` must still be high. Finally it reads back channel B's distinct sample through the normal read path once B finishes. A second delicate case is the interrupt release of R5: it must first drive `int_n` low with a completed conversion, then show that a DAC-side write leaves it low, and that an ADC-side read or a bare ADC-side write strobe raises it.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
        logic sel_dac;
        logic sel_chb;
    } bus_ctl_t;

    typedef struct packed {
        logic  dac_load;
        logic  conv_start;
        logic  int_release;
        logic  read_en;
        chan_e chan;
    } bus_evt_t;

    localparam bus_ctl_t CTL_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                      sel_dac: 1'b0, sel_chb: 1'b0};

    function automatic logic [31:0] mid_code(input int unsigned width);
        return 32'd1 << (width - 1);
    endfunction

endpackage

// File: rtl/dcb_sync.sv
module dcb_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcb_decode.sv
module dcb_decode
    import dcb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_ctl_t ctl,
    output bus_evt_t evt
);
    logic prev_rd_n;
    logic prev_wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rd_n <= 1'b1;
            prev_wr_n <= 1'b1;
        end else begin
            prev_rd_n <= ctl.rd_n;
            prev_wr_n <= ctl.wr_n;
        end
    end

    logic selected;
    logic adc_side;
    logic wr_rise;
    logic wr_fall;
    logic rd_fall;

    always_comb begin
        selected = ~ctl.cs_n;
        adc_side = selected & ~ctl.sel_dac;
        wr_rise  = ctl.wr_n & ~prev_wr_n;
        wr_fall  = ~ctl.wr_n & prev_wr_n;
        rd_fall  = ~ctl.rd_n & prev_rd_n;

        evt.dac_load    = selected & ctl.sel_dac & wr_rise;
        evt.conv_start  = adc_side & wr_rise;
        evt.int_release = adc_side & (wr_fall | rd_fall);
        evt.read_en     = adc_side & ~ctl.rd_n;
        evt.chan        = chan_e'(ctl.sel_chb);
    end
endmodule

// File: rtl/dcb_conv.sv
module dcb_conv
    import dcb_pkg::*;
#(
    parameter int W   = 8,
    parameter int LAT = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  chan_e        chan,
    input  logic         release_irq,
    input  logic [W-1:0] samp_a,
    input  logic [W-1:0] samp_b,
    output logic [W-1:0] result,
    output logic         int_n
);
    localparam int          CW    = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LOAD  = CW'(LAT - 1);
    localparam logic [W-1:0]  MID   = W'(mid_code(W));

    logic          busy;
    logic [CW-1:0] remain;
    chan_e         cur_ch;
    logic          finish;

    assign finish = busy & (remain == '0) & ~start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            cur_ch <= CH_A;
            result <= MID;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= LOAD;
            cur_ch <= chan;
        end else if (busy) begin
            if (remain == '0) begin
                busy   <= 1'b0;
                result <= (cur_ch == CH_B) ? samp_b : samp_a;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              int_n <= 1'b1;
        else if (finish)      int_n <= 1'b0;
        else if (release_irq) int_n <= 1'b1;
    end
endmodule

// File: rtl/dcb_dac_regs.sv
module dcb_dac_regs
    import dcb_pkg::*;
#(
    parameter int W   = 8,
    parameter int NCH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  chan_e                 chan,
    input  logic [W-1:0]          din,
    output logic [NCH-1:0][W-1:0] codes
);
    localparam logic [W-1:0] MID = W'(mid_code(W));

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst)
                    codes[c] <= MID;
                else if (load && (int'(chan) == c))
                    codes[c] <= din;
            end
        end
    endgenerate
endmodule

// File: rtl/dualconv_bus.sv
module dualconv_bus
    import dcb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CONV_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              sel_dac,
    input  logic              sel_chb,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [DATA_W-1:0] samp_a,
    input  logic [DATA_W-1:0] samp_b,
    output logic [DATA_W-1:0] dac_a_code,
    output logic [DATA_W-1:0] dac_b_code,
    output logic              int_n
);
    localparam int CTL_W  = $bits(bus_ctl_t);
    localparam int BUS_W  = CTL_W + DATA_W;
    localparam int NCH    = 2;

    bus_ctl_t          raw_ctl;
    bus_ctl_t          s_ctl;
    logic [DATA_W-1:0] s_data;
    logic [BUS_W-1:0]  sync_q;
    bus_evt_t          evt;
    logic [DATA_W-1:0] result;
    logic [NCH-1:0][DATA_W-1:0] codes;

    always_comb begin
        raw_ctl.cs_n    = cs_n;
        raw_ctl.rd_n    = rd_n;
        raw_ctl.wr_n    = wr_n;
        raw_ctl.sel_dac = sel_dac;
        raw_ctl.sel_chb = sel_chb;
    end

    dcb_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({CTL_IDLE, {DATA_W{1'b0}}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({raw_ctl, data_in}),
        .q   (sync_q)
    );

    assign s_ctl  = bus_ctl_t'(sync_q[BUS_W-1:DATA_W]);
    assign s_data = sync_q[DATA_W-1:0];

    dcb_decode u_decode (
        .clk (clk),
        .rst (rst),
        .ctl (s_ctl),
        .evt (evt)
    );

    dcb_dac_regs #(
        .W   (DATA_W),
        .NCH (NCH)
    ) u_dac (
        .clk   (clk),
        .rst   (rst),
        .load  (evt.dac_load),
        .chan  (evt.chan),
        .din   (s_data),
        .codes (codes)
    );

    dcb_conv #(
        .W   (DATA_W),
        .LAT (CONV_CYCLES)
    ) u_conv (
        .clk         (clk),
        .rst         (rst),
        .start       (evt.conv_start),
        .chan        (evt.chan),
        .release_irq (evt.int_release),
        .samp_a      (samp_a),
        .samp_b      (samp_b),
        .result      (result),
        .int_n       (int_n)
    );

    assign dac_a_code = codes[0];
    assign dac_b_code = codes[1];
    assign data_oe    = evt.read_en;
    assign data_out   = evt.read_en ? result : '0;
endmodule

// File: rtl/dualconv_bus_chk.sv
module dualconv_bus_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cs_n,
    input logic         rd_n,
    input logic         wr_n,
    input logic         sel_dac,
    input logic         sel_chb,
    input logic         data_oe,
    input logic         int_n,
    input logic [W-1:0] dac_a_code,
    input logic [W-1:0] dac_b_code
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic [2:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end
    assign warm = (since_rst >= 3'd5);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (int_n && !data_oe && dac_a_code == MID && dac_b_code == MID));

    // R2
    dac_a_load_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && !$stable(dac_a_code)) |->
        ($past(wr_n, 3) && !$past(wr_n, 4) && !$past(cs_n, 3) &&
         $past(sel_dac, 3) && !$past(sel_chb, 3)));

    // R2
    dac_b_load_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && !$stable(dac_b_code)) |->
        ($past(wr_n, 3) && !$past(wr_n, 4) && !$past(cs_n, 3) &&
         $past(sel_dac, 3) && $past(sel_chb, 3)));

    // R5
    int_release_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && $rose(int_n)) |->
        (!$past(cs_n, 3) && !$past(sel_dac, 3) &&
         ((!$past(wr_n, 3) && $past(wr_n, 4)) || (!$past(rd_n, 3) && $past(rd_n, 4)))));

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && data_oe) |->
        (!$past(cs_n, 2) && !$past(rd_n, 2) && !$past(sel_dac, 2)));
endmodule

bind dualconv_bus dualconv_bus_chk #(.W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .sel_dac    (sel_dac),
    .sel_chb    (sel_chb),
    .data_oe    (data_oe),
    .int_n      (int_n),
    .dac_a_code (dac_a_code),
    .dac_b_code (dac_b_code)
);

// File: tb/dualconv_bus_tb.sv
module dualconv_bus_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_dac = 1'b0, sel_chb = 1'b0;
    logic [7:0] data_in = 8'h00, samp_a = 8'h00, samp_b = 8'h00;
    logic [7:0] data_out, dac_a_code, dac_b_code;
    logic       data_oe, int_n;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } rd_item_t;
    rd_item_t sb_q[$];
    event     mon_ev;

    always #10 clk = ~clk;

    dualconv_bus u_dut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .sel_dac (sel_dac), .sel_chb (sel_chb), .data_in (data_in),
        .data_out (data_out), .data_oe (data_oe), .samp_a (samp_a),
        .samp_b (samp_b), .dac_a_code (dac_a_code), .dac_b_code (dac_b_code),
        .int_n (int_n)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic dac, input logic chb, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; sel_dac = dac; sel_chb = chb; data_in = d; wr_n = 1'b0;
        cyc(4);
        wr_n = 1'b1;
        cyc(2);
        cs_n = 1'b1;
        cyc(1);
    endtask

    // scoreboard driver: ADC read, pushes expected byte for monitor
    task automatic adc_read(input logic [7:0] exp, input string req);
        @(negedge clk);
        cs_n = 1'b0; sel_dac = 1'b0; rd_n = 1'b0;
        cyc(4);
        sb_q.push_back('{exp: exp, req: req});
        ->mon_ev;
        cyc(1);
        rd_n = 1'b1; cs_n = 1'b1;
        cyc(4);
        check("R6", "oe after read", {7'd0, data_oe}, 8'h00);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.req, "oe during read", {7'd0, data_oe}, 8'h01);
                check(it.req, "read data", data_out, it.exp);
            end
        end
    end

    initial begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog expired got timeout exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(2);
        // R1 reset state
        check("R1", "dac_a", dac_a_code, 8'h80);
        check("R1", "dac_b", dac_b_code, 8'h80);
        check("R1", "int_n", {7'd0, int_n}, 8'h01);
        check("R1", "oe", {7'd0, data_oe}, 8'h00);

        // R2 DAC writes per channel
        bus_write(1'b1, 1'b0, 8'h3C);
        cyc(2);
        check("R2", "dac_a", dac_a_code, 8'h3C);
        check("R2", "dac_b untouched", dac_b_code, 8'h80);
        bus_write(1'b1, 1'b1, 8'hE1);
        cyc(2);
        check("R2", "dac_b", dac_b_code, 8'hE1);
        check("R2", "dac_a untouched", dac_a_code, 8'h3C);

        // R3 chip select high: nothing happens
        @(negedge clk);
        sel_dac = 1'b1; sel_chb = 1'b0; data_in = 8'h55; wr_n = 1'b0;
        cyc(4); wr_n = 1'b1; cyc(4);
        check("R3", "dac_a with cs high", dac_a_code, 8'h3C);
        sel_dac = 1'b0; samp_a = 8'h21; wr_n = 1'b0; cyc(4); wr_n = 1'b1;
        cyc(30);
        check("R3", "no conversion int_n", {7'd0, int_n}, 8'h01);
        rd_n = 1'b0; cyc(4);
        check("R3", "no oe with cs high", {7'd0, data_oe}, 8'h00);
        rd_n = 1'b1; cyc(2);

        // R4 conversion on A
        samp_a = 8'hA7; samp_b = 8'h19;
        bus_write(1'b0, 1'b0, 8'h00);
        cyc(4);
        check("R4", "int_n still busy", {7'd0, int_n}, 8'h01);
        cyc(25);
        check("R4", "int_n after done", {7'd0, int_n}, 8'h00);
        // R8 DAC-side write leaves interrupt alone
        bus_write(1'b1, 1'b1, 8'h42);
        cyc(2);
        check("R8", "int_n after dac write", {7'd0, int_n}, 8'h00);
        check("R2", "dac_b reload", dac_b_code, 8'h42);
        // R6 read of DAC side: bus stays off
        @(negedge clk);
        cs_n = 1'b0; sel_dac = 1'b1; rd_n = 1'b0; cyc(4);
        check("R6", "oe on dac read", {7'd0, data_oe}, 8'h00);
        check("R8", "int_n after dac read", {7'd0, int_n}, 8'h00);
        rd_n = 1'b1; cs_n = 1'b1; cyc(3);
        adc_read(8'hA7, "R4");
        check("R5", "int_n after rd fall", {7'd0, int_n}, 8'h01);

        // R4 conversion on B
        bus_write(1'b0, 1'b1, 8'h00);
        cyc(30);
        check("R4", "int_n done B", {7'd0, int_n}, 8'h00);
        adc_read(8'h19, "R4");

        // R5 release by write falling edge
        samp_a = 8'hFE;
        bus_write(1'b0, 1'b0, 8'h00);
        cyc(30);
        check("R4", "int_n done A2", {7'd0, int_n}, 8'h00);
        @(negedge clk);
        cs_n = 1'b0; sel_dac = 1'b0; sel_chb = 1'b0; wr_n = 1'b0;
        cyc(5);
        check("R5", "int_n after wr fall", {7'd0, int_n}, 8'h01);
        wr_n = 1'b1; cyc(2); cs_n = 1'b1;
        cyc(30);
        adc_read(8'hFE, "R6");

        // R7 restart while busy
        samp_a = 8'h11; samp_b = 8'h99;
        bus_write(1'b0, 1'b0, 8'h00);
        cyc(4);
        bus_write(1'b0, 1'b1, 8'h00);
        cyc(7);
        check("R7", "int_n after abandoned finish", {7'd0, int_n}, 8'h01);
        cyc(20);
        check("R7", "int_n restart done", {7'd0, int_n}, 8'h00);
        adc_read(8'h99, "R7");

        cyc(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule